// File: doc/BRIEF.md
# GPIO Port Pad Control Logic

This block controls the pads of an 8-pin general-purpose I/O port. Four per-pin registers sit behind a small synchronous register bus: pin direction, output data, input pull-up enable and open-drain enable. From these registers and a 3-bit operating-mode input, the block produces four registered per-pin pad controls: output enable, pull-up enable, PMOS (high-side) drive enable and NMOS (low-side) drive enable.

The operating mode limits what the pull-up and open-drain settings can do. Register reads always return the stored bits, whatever the mode. Reset handling depends on the reset type. A power-on reset clears every register. Hardware standby clears only the pull-up and open-drain registers. Manual reset and software standby keep all stored state, and they block writes while they are asserted.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: While `por_rst` is high at a rising edge, all four registers are cleared to 0x00. `rd_data` and all pad outputs are 0 after that edge.
- R2: Register select codes are 0 = direction, 1 = output data, 2 = pull-up enable, 3 = open-drain enable. A write takes effect at a rising edge when `wr_en` is high. `rd_data` is registered: after each edge it holds the pre-edge value of the register that `sel` addressed. All 8 stored bits read back in every mode.
- R3: `pad_oe[i]` equals direction bit i, where 1 means output. `pad_nmos_en[i]` is 1 exactly when the pin is an output and its data bit is 0.
- R4: `pad_pu[i]` can be 1 only when direction bit i is 0 and pull-up bit i is 1.
- R5: Pull-up bits all take effect in modes 1, 2, 3, 6 and 7. In modes 4 and 5 only bits 7 to 5 take effect, and `pad_pu[4:0]` is 0. In mode 0 no pull-up bit takes effect.
- R6: In modes 1, 2, 3 and 7, an output pin whose open-drain bit is 1 never enables its PMOS. It drives low only through NMOS when its data bit is 0, and it is released when its data bit is 1.
- R7: In modes 0, 4, 5 and 6, and for pins whose open-drain bit is 0, an output pin is push-pull: `pad_pmos_en[i]` equals data bit i.
- R8: A cycle with `hw_stby` high clears the pull-up and open-drain registers, blocks writes, and keeps the direction and data registers.
- R9: While `man_rst` or `sw_stby` is high, every register keeps its value and writes are ignored.
- R10: Pad outputs are registered. A change to a register or to `mode` shows on the pads one clock edge after it happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, keeps registers, blocks writes |
| hw_stby | input | 1 | Hardware standby, clears pull-up and open-drain registers |
| sw_stby | input | 1 | Software standby, keeps registers, blocks writes |
| mode | input | 3 | Operating mode |
| wr_en | input | 1 | Register write strobe |
| sel | input | 2 | Register select for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pad_pmos_en | output | 8 | Per-pin high-side drive enable |
| pad_nmos_en | output | 8 | Per-pin low-side drive enable |

## Verification
The assertions assume that `por_rst` is held for at least two edges at start-up, and that the reset and standby inputs are never unknown. The standby and hold checks look two edges back, so they assume that the inputs were driven from time zero. The stimulus drives every input to a defined value before the first edge. It changes inputs only on the falling edge and holds `por_rst` for several cycles. Each standby or manual-reset pulse lasts one full clock, and a write is always applied together with the pulse so that write blocking is exercised.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int NUM_REGS = 4;
  localparam int SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    REG_DIR  = 2'd0,
    REG_OUT  = 2'd1,
    REG_PULL = 2'd2,
    REG_ODRN = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_pad_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             hw_stby,
  input  logic             hold,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     pull_q,
  output logic [W-1:0]     odrn_q,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] bank [NUM_REGS];
  logic         wr_ok;

  // Writes are blocked by any reset or standby input.
  assign wr_ok = wr_en && !hw_stby && !hold;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    // Pull-up and open-drain registers are also cleared by hardware standby.
    localparam bit STBY_CLR = (r == int'(REG_PULL)) || (r == int'(REG_ODRN));
    always_ff @(posedge clk) begin
      if (por_rst) begin
        bank[r] <= '0;
      end else if (STBY_CLR && hw_stby) begin
        bank[r] <= '0;
      end else if (wr_ok && (sel == SEL_W'(r))) begin
        bank[r] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst) rd_data <= '0;
    else         rd_data <= bank[sel];
  end

  assign dir_q  = bank[REG_DIR];
  assign out_q  = bank[REG_OUT];
  assign pull_q = bank[REG_PULL];
  assign odrn_q = bank[REG_ODRN];
endmodule

// File: rtl/gpio_mode_decode.sv
module gpio_mode_decode #(
  parameter int           W               = 8,
  parameter int           MODE_W          = 3,
  parameter logic [W-1:0] PU_PARTIAL_MASK = 8'hE0
) (
  input  logic [MODE_W-1:0] mode,
  output logic [W-1:0]      pu_mask,
  output logic              od_allow
);
  localparam logic [W-1:0] ALL_ON = {W{1'b1}};

  always_comb begin
    pu_mask  = '0;
    od_allow = 1'b0;
    case (mode)
      MODE_W'(1), MODE_W'(2), MODE_W'(3), MODE_W'(7): begin
        pu_mask  = ALL_ON;
        od_allow = 1'b1;
      end
      MODE_W'(6): pu_mask = ALL_ON;
      MODE_W'(4), MODE_W'(5): pu_mask = PU_PARTIAL_MASK;
      default: begin
        pu_mask  = '0;
        od_allow = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_rst,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] pull_q,
  input  logic [W-1:0] odrn_q,
  input  logic [W-1:0] pu_mask,
  input  logic         od_allow,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pad_pmos_en,
  output logic [W-1:0] pad_nmos_en
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic od_on;
    assign od_on = odrn_q[i] && od_allow;

    always_ff @(posedge clk) begin
      if (por_rst) begin
        pad_oe[i]      <= 1'b0;
        pad_pu[i]      <= 1'b0;
        pad_pmos_en[i] <= 1'b0;
        pad_nmos_en[i] <= 1'b0;
      end else begin
        pad_oe[i]      <= dir_q[i];
        pad_pu[i]      <= !dir_q[i] && pull_q[i] && pu_mask[i];
        pad_pmos_en[i] <= dir_q[i] && out_q[i] && !od_on;
        pad_nmos_en[i] <= dir_q[i] && !out_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int           W               = 8,
  parameter int           MODE_W          = 3,
  parameter logic [W-1:0] PU_PARTIAL_MASK = 8'hE0
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              man_rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [MODE_W-1:0] mode,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pu,
  output logic [W-1:0]      pad_pmos_en,
  output logic [W-1:0]      pad_nmos_en
);
  logic [W-1:0] dir_q, out_q, pull_q, odrn_q, pu_mask;
  logic         od_allow;

  gpio_ctrl_regs #(.W(W)) u_regs (
    .clk     (clk),
    .por_rst (por_rst),
    .hw_stby (hw_stby),
    .hold    (man_rst | sw_stby),
    .wr_en   (wr_en),
    .sel     (sel),
    .wr_data (wr_data),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .pull_q  (pull_q),
    .odrn_q  (odrn_q),
    .rd_data (rd_data)
  );

  gpio_mode_decode #(.W(W), .MODE_W(MODE_W), .PU_PARTIAL_MASK(PU_PARTIAL_MASK)) u_mode (
    .mode     (mode),
    .pu_mask  (pu_mask),
    .od_allow (od_allow)
  );

  gpio_pad_drive #(.W(W)) u_drive (
    .clk         (clk),
    .por_rst     (por_rst),
    .dir_q       (dir_q),
    .out_q       (out_q),
    .pull_q      (pull_q),
    .odrn_q      (odrn_q),
    .pu_mask     (pu_mask),
    .od_allow    (od_allow),
    .pad_oe      (pad_oe),
    .pad_pu      (pad_pu),
    .pad_pmos_en (pad_pmos_en),
    .pad_nmos_en (pad_nmos_en)
  );
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int W      = 8,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              por_rst,
  input logic              man_rst,
  input logic              hw_stby,
  input logic              sw_stby,
  input logic [MODE_W-1:0] mode,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_pu,
  input logic [W-1:0]      pad_pmos_en,
  input logic [W-1:0]      pad_nmos_en
);
  // R4
  pu_only_input_chk: assert property (@(posedge clk) disable iff (por_rst)
    (pad_pu & pad_oe) == '0);

  // R6
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (por_rst)
    (pad_pmos_en & pad_nmos_en) == '0);

  // R3
  nmos_needs_oe_chk: assert property (@(posedge clk) disable iff (por_rst)
    (pad_nmos_en & ~pad_oe) == '0);

  // R5
  partial_pu_mode_chk: assert property (@(posedge clk) disable iff (por_rst)
    ($past(mode) == MODE_W'(4) || $past(mode) == MODE_W'(5)) |-> pad_pu[4:0] == '0);

  // R8
  stby_clears_pu_chk: assert property (@(posedge clk) disable iff (por_rst)
    $past(hw_stby, 2) |-> pad_pu == '0);

  // R9
  hold_keeps_dir_chk: assert property (@(posedge clk) disable iff (por_rst)
    ($past(man_rst, 2) || $past(sw_stby, 2)) |-> $stable(pad_oe));
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.W(W), .MODE_W(MODE_W)) u_chk (
  .clk         (clk),
  .por_rst     (por_rst),
  .man_rst     (man_rst),
  .hw_stby     (hw_stby),
  .sw_stby     (sw_stby),
  .mode        (mode),
  .pad_oe      (pad_oe),
  .pad_pu      (pad_pu),
  .pad_pmos_en (pad_pmos_en),
  .pad_nmos_en (pad_nmos_en)
);

// File: tb/sim_gpio_pad_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_pad_ctrl;
  logic       clk = 1'b0;
  logic       por_rst = 1'b1, man_rst = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0;
  logic [2:0] mode = 3'd1;
  logic       wr_en = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, pad_oe, pad_pu, pad_pmos_en, pad_nmos_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the registers
  logic [7:0] m_reg [4];

  // scoreboard queues
  int         fq[$];
  logic [7:0] eq[$];
  string      rq[$];
  event       chk_ev;

  always #2 clk = ~clk;

  gpio_pad_ctrl u0 (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .mode(mode), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
    .rd_data(rd_data), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_pmos_en(pad_pmos_en), .pad_nmos_en(pad_nmos_en)
  );

  function automatic logic [7:0] pu_mask(input logic [2:0] md);
    case (md)
      3'd1, 3'd2, 3'd3, 3'd6, 3'd7: return 8'hFF;
      3'd4, 3'd5: return 8'hE0;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit od_mode(input logic [2:0] md);
    return (md == 3'd1 || md == 3'd2 || md == 3'd3 || md == 3'd7);
  endfunction

  task automatic push(input int f, input logic [7:0] e, input string r);
    fq.push_back(f); eq.push_back(e); rq.push_back(r);
  endtask

  // monitor: compare queued expectations against outputs
  initial begin
    forever begin
      @(chk_ev);
      while (fq.size() > 0) begin
        int f;
        logic [7:0] e, a;
        string r, nm;
        f = fq.pop_front(); e = eq.pop_front(); r = rq.pop_front();
        case (f)
          0: begin a = rd_data;     nm = "rd_data";     end
          1: begin a = pad_oe;      nm = "pad_oe";      end
          2: begin a = pad_pu;      nm = "pad_pu";      end
          3: begin a = pad_pmos_en; nm = "pad_pmos_en"; end
          default: begin a = pad_nmos_en; nm = "pad_nmos_en"; end
        endcase
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s %s actual=%02h expected=%02h", r, nm, a, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_reg[s] = d;
  endtask

  // Select register, wait one edge, then check read data and all pads.
  task automatic look(input logic [1:0] s, input string r);
    logic [7:0] od;
    sel = s;
    @(negedge clk);
    od = od_mode(mode) ? m_reg[3] : 8'h00;
    push(0, m_reg[s], r);
    push(1, m_reg[0], r);
    push(2, ~m_reg[0] & m_reg[2] & pu_mask(mode), r);
    push(3, m_reg[0] & m_reg[1] & ~od, r);
    push(4, m_reg[0] & ~m_reg[1], r);
    -> chk_ev;
    #0;
  endtask

  task automatic look_all(input string r);
    for (int s = 0; s < 4; s++) look(2'(s), r);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    repeat (4) @(negedge clk);
    por_rst = 1'b0;
    // R1: reset state
    look_all("R1");

    // R2 R3 R4 R6: main function in mode 1
    wr(2'd0, 8'h0F); wr(2'd1, 8'h35); wr(2'd2, 8'hFF); wr(2'd3, 8'h0C);
    look_all("R2");

    // R5 R6 R7: sweep every mode with same register contents
    for (int md = 0; md < 8; md++) begin
      @(negedge clk); mode = 3'(md);
      look(2'd3, (md == 4 || md == 5) ? "R5" : (od_mode(3'(md)) ? "R6" : "R7"));
    end

    // R4: other patterns, input pins with pull-ups
    @(negedge clk); mode = 3'd6;
    wr(2'd0, 8'hA5); wr(2'd1, 8'hF0); wr(2'd2, 8'h5A); wr(2'd3, 8'h00);
    look(2'd2, "R4");
    // R7: all open-drain set but mode 6 is push-pull
    wr(2'd3, 8'hFF);
    look(2'd3, "R7");
    // R6: open-drain released and low cases in mode 7
    @(negedge clk); mode = 3'd7;
    look(2'd1, "R6");
    // R5: reads return ineffective bits in mode 4
    @(negedge clk); mode = 3'd4;
    wr(2'd0, 8'h00); wr(2'd2, 8'hFF);
    look(2'd2, "R5");

    // R10: pad lags a register write by one edge
    @(negedge clk);
    wr_en = 1'b1; sel = 2'd0; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
    checks++;
    if (pad_oe !== 8'h00) begin
      errors++;
      $display("FAIL R10 pad_oe actual=%02h expected=%02h", pad_oe, 8'h00);
    end
    m_reg[0] = 8'hFF;
    look(2'd0, "R10");

    // R9: manual reset with write, registers kept
    @(negedge clk);
    man_rst = 1'b1; wr_en = 1'b1; sel = 2'd1; wr_data = 8'h00;
    @(negedge clk);
    man_rst = 1'b0; wr_en = 1'b0;
    look_all("R9");
    // R9: software standby with write
    @(negedge clk);
    sw_stby = 1'b1; wr_en = 1'b1; sel = 2'd0; wr_data = 8'h00;
    @(negedge clk);
    sw_stby = 1'b0; wr_en = 1'b0;
    look_all("R9");

    // R8: hardware standby with write attempt to direction
    @(negedge clk); mode = 3'd1;
    hw_stby = 1'b1; wr_en = 1'b1; sel = 2'd0; wr_data = 8'h11;
    @(negedge clk);
    hw_stby = 1'b0; wr_en = 1'b0;
    m_reg[2] = 8'h00; m_reg[3] = 8'h00;
    look_all("R8");

    // R1: power-on reset mid-run with write
    wr(2'd2, 8'h3C); wr(2'd3, 8'hC3);
    @(negedge clk);
    por_rst = 1'b1; wr_en = 1'b1; sel = 2'd1; wr_data = 8'hAA;
    @(negedge clk);
    por_rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    look_all("R1");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule